// File: doc/BRIEF.md
# Virtualized Timer Offset CSR Unit

This unit is a slice of a processor's control and status register file for a hart with hypervisor support. It owns one 64-bit offset register that the hypervisor programs. It answers reads of the time counter. While the hart runs as a virtualized guest, a time read returns the free-running counter plus that offset. Otherwise it returns the counter unchanged. The counter itself, trap delivery and every other CSR live elsewhere. This unit only classifies an access, serves its data and raises a fault flag that the trap logic consumes.

A parameter `XLEN` picks a 32-bit or a 64-bit register width. With 64 bits the offset is a single CSR. With 32 bits it is split into a low-half CSR and a high-half CSR, and the counter also has a separate high-half CSR. Each access is classified in the cycle it is presented. A small response state machine (`RSP_IDLE`, `RSP_DATA`, `RSP_ACK`, `RSP_FAULT`) registers the outcome, so the read data and the fault flag appear one cycle later. The machine's next state is chosen afresh every cycle:
- no access, or an address this unit does not own, goes to `RSP_IDLE`;
- a denied access goes to `RSP_FAULT`;
- a permitted read goes to `RSP_DATA`;
- a permitted write with no read goes to `RSP_ACK`.

Top module: `vtimedelta_csr`

## Requirements
- R1: After reset the offset is zero, so a virtualized time read returns the raw counter; during reset both outputs are zero.
- R2: A read of address 0xC01 with `virt_i`=0 returns `time_i` (its low XLEN bits) unchanged.
- R3: A read of 0xC01 with `virt_i`=1 returns the low XLEN bits of (`time_i` + offset) mod 2^64, with carries crossing bit 32.
- R4: With XLEN=64, a permitted write to 0xA01 replaces all 64 offset bits, and a read of 0xA01 returns them.
- R5: With XLEN=32, 0xA01 holds offset bits 31:0 and 0xA81 holds bits 63:32; a write to one half leaves the other half unchanged.
- R6: With XLEN=32, a read of 0xC81 returns bits 63:32 of the selected 64-bit time value: the full sum when `virt_i`=1, the raw counter otherwise.
- R7: Offset accesses (0xA01, 0xA81) are permitted only with `virt_i`=0 and `priv_i` equal to 1 (supervisor) or 3 (machine). A denied access raises `csr_illegal_o` and leaves the offset unchanged.
- R8: With XLEN=64, any access to 0xA81 or 0xC81 raises `csr_illegal_o`.
- R9: A write to 0xC01 or 0xC81 raises `csr_illegal_o` and changes nothing.
- R10: An access to any other address gives `csr_illegal_o`=0 and `csr_rdata_o`=0.
- R11: Results appear in the cycle after the access. In a cycle that follows no read, `csr_rdata_o` is 0. In a cycle that follows no access, `csr_illegal_o` is 0. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Free-running time counter |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Hart runs as a virtualized guest |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_we_i | input | 1 | CSR write enable |
| csr_re_i | input | 1 | CSR read enable |
| csr_rdata_o | output | XLEN | Read data, one cycle after the read |
| csr_illegal_o | output | 1 | Access fault, one cycle after the access |

## Verification
Both the read data and the fault flag are registered once, so each result is due exactly one clock edge after the cycle in which the access is presented. An offset write takes effect on that same edge and is visible to the next access. The bench drives every access on a falling edge and samples the outputs on the following falling edge, after the single rising edge that produces them. It updates its own model of the offset only after that check, so a same-cycle read expects the value held before the write. A 64-bit and a 32-bit instance receive the same stimulus, and each is checked against expectations derived for its own width.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

    localparam logic [11:0] ADDR_OFS_LO  = 12'hA01;
    localparam logic [11:0] ADDR_OFS_HI  = 12'hA81;
    localparam logic [11:0] ADDR_TIME_LO = 12'hC01;
    localparam logic [11:0] ADDR_TIME_HI = 12'hC81;

    localparam int TIME_W = 64;
    localparam int HALF_W = TIME_W / 2;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OFS_LO,
        TGT_OFS_HI,
        TGT_TIME_LO,
        TGT_TIME_HI
    } tgt_e;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_ACK,
        RSP_FAULT
    } rsp_e;

endpackage

// File: rtl/vtd_decode.sv
module vtd_decode
    import vtd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0] addr_i,
    input  logic        we_i,
    input  logic        re_i,
    input  logic [1:0]  priv_i,
    input  logic        virt_i,
    output tgt_e        tgt_o,
    output logic        legal_o,
    output logic        active_o,
    output logic        wr_lo_o,
    output logic        wr_hi_o
);
    localparam bit IS32 = (XLEN == 32);

    priv_e priv;
    logic  hs_ok;

    always_comb begin
        priv  = priv_e'(priv_i);
        hs_ok = !virt_i && (priv == PRIV_S || priv == PRIV_M);
    end

    always_comb begin
        unique case (addr_i)
            ADDR_OFS_LO:  tgt_o = TGT_OFS_LO;
            ADDR_OFS_HI:  tgt_o = TGT_OFS_HI;
            ADDR_TIME_LO: tgt_o = TGT_TIME_LO;
            ADDR_TIME_HI: tgt_o = TGT_TIME_HI;
            default:      tgt_o = TGT_NONE;
        endcase
    end

    always_comb begin
        unique case (tgt_o)
            TGT_OFS_LO:  legal_o = hs_ok;
            TGT_OFS_HI:  legal_o = IS32 && hs_ok;
            TGT_TIME_LO: legal_o = !we_i;
            TGT_TIME_HI: legal_o = IS32 && !we_i;
            default:     legal_o = 1'b1;
        endcase
    end

    always_comb begin
        active_o = (we_i || re_i) && (tgt_o != TGT_NONE);
        wr_lo_o  = we_i && legal_o && (tgt_o == TGT_OFS_LO);
        wr_hi_o  = we_i && legal_o && (tgt_o == TGT_OFS_HI);
    end

endmodule

// File: rtl/vtd_offset_reg.sv
module vtd_offset_reg
    import vtd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [TIME_W-1:0] ofs_o
);
    logic [TIME_W-1:0] ofs_q;

    generate
        if (XLEN == TIME_W) begin : g_full
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ofs_q <= '0;
                end else if (wr_lo_i) begin
                    ofs_q <= TIME_W'(wdata_i);
                end else if (wr_hi_i) begin
                    ofs_q[TIME_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
                end
            end
        end else begin : g_split
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ofs_q <= '0;
                end else begin
                    if (wr_lo_i) ofs_q[HALF_W-1:0]      <= wdata_i[HALF_W-1:0];
                    if (wr_hi_i) ofs_q[TIME_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
                end
            end
        end
    endgenerate

    assign ofs_o = ofs_q;

endmodule

// File: rtl/vtd_time_view.sv
module vtd_time_view
    import vtd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] ofs_i,
    input  logic              virt_i,
    input  tgt_e              tgt_i,
    output logic [XLEN-1:0]   value_o
);
    logic [TIME_W-1:0] guest_time;
    logic [TIME_W-1:0] seen_time;

    always_comb begin
        guest_time = time_i + ofs_i;
        seen_time  = virt_i ? guest_time : time_i;
    end

    always_comb begin
        unique case (tgt_i)
            TGT_OFS_LO:  value_o = ofs_i[XLEN-1:0];
            TGT_OFS_HI:  value_o = XLEN'(ofs_i[TIME_W-1:HALF_W]);
            TGT_TIME_LO: value_o = seen_time[XLEN-1:0];
            TGT_TIME_HI: value_o = XLEN'(seen_time[TIME_W-1:HALF_W]);
            default:     value_o = '0;
        endcase
    end

endmodule

// File: rtl/vtimedelta_csr.sv
module vtimedelta_csr
    import vtd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       time_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    input  logic              csr_we_i,
    input  logic              csr_re_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o
);
    tgt_e              tgt_w;
    logic              legal_w;
    logic              active_w;
    logic              wr_lo_w;
    logic              wr_hi_w;
    logic [TIME_W-1:0] delta_w;
    logic [XLEN-1:0]   value_w;

    rsp_e              rsp_q;
    rsp_e              rsp_d;
    logic [XLEN-1:0]   data_q;

    vtd_decode #(.XLEN(XLEN)) u_decode (
        .addr_i   (csr_addr_i),
        .we_i     (csr_we_i),
        .re_i     (csr_re_i),
        .priv_i   (priv_i),
        .virt_i   (virt_i),
        .tgt_o    (tgt_w),
        .legal_o  (legal_w),
        .active_o (active_w),
        .wr_lo_o  (wr_lo_w),
        .wr_hi_o  (wr_hi_w)
    );

    vtd_offset_reg #(.XLEN(XLEN)) u_offset (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo_i (wr_lo_w),
        .wr_hi_i (wr_hi_w),
        .wdata_i (csr_wdata_i),
        .ofs_o   (delta_w)
    );

    vtd_time_view #(.XLEN(XLEN)) u_view (
        .time_i  (time_i),
        .ofs_i   (delta_w),
        .virt_i  (virt_i),
        .tgt_i   (tgt_w),
        .value_o (value_w)
    );

    // Next response: chosen each cycle from the access being presented.
    always_comb begin
        if (!active_w)      rsp_d = RSP_IDLE;
        else if (!legal_w)  rsp_d = RSP_FAULT;
        else if (csr_re_i)  rsp_d = RSP_DATA;
        else                rsp_d = RSP_ACK;
    end

    // State register and captured read value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q  <= RSP_IDLE;
            data_q <= '0;
        end else begin
            rsp_q  <= rsp_d;
            data_q <= (rsp_d == RSP_DATA) ? value_w : '0;
        end
    end

    // Outputs driven from the response state.
    always_comb begin
        unique case (rsp_q)
            RSP_DATA: begin
                csr_rdata_o   = data_q;
                csr_illegal_o = 1'b0;
            end
            RSP_FAULT: begin
                csr_rdata_o   = '0;
                csr_illegal_o = 1'b1;
            end
            default: begin
                csr_rdata_o   = '0;
                csr_illegal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vtd_unit_chk.sv
module vtd_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [63:0]     time_i,
    input logic [1:0]      priv_i,
    input logic            virt_i,
    input logic [11:0]     csr_addr_i,
    input logic            csr_we_i,
    input logic            csr_re_i,
    input logic [XLEN-1:0] csr_rdata_o,
    input logic            csr_illegal_o,
    input logic [63:0]     delta
);
    logic known;
    assign known = (csr_addr_i == 12'hA01) || (csr_addr_i == 12'hA81) ||
                   (csr_addr_i == 12'hC01) || (csr_addr_i == 12'hC81);

    // R11: no read in the previous cycle means zero read data
    a_r11_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_re_i |=> csr_rdata_o == '0);

    // R11: no access in the previous cycle means no fault
    a_r11_no_spurious_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_re_i || csr_we_i) |=> !csr_illegal_o);

    // R2: outside virtualization the counter is returned unchanged
    a_r2_raw_time: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_re_i && !csr_we_i && !virt_i && csr_addr_i == 12'hC01)
        |=> csr_rdata_o == XLEN'($past(time_i)));

    // R7: a denied offset write leaves the offset unchanged
    a_r7_offset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && (csr_addr_i == 12'hA01 || csr_addr_i == 12'hA81) &&
         (virt_i || priv_i == 2'd0))
        |=> csr_illegal_o && $stable(delta));

    // R8: high-half addresses fault in the 64-bit configuration
    a_r8_hi_absent: assert property (@(posedge clk) disable iff (!rst_n)
        ((XLEN == 64) && (csr_re_i || csr_we_i) &&
         (csr_addr_i == 12'hA81 || csr_addr_i == 12'hC81))
        |=> csr_illegal_o);

    // R9: the counter is read-only
    a_r9_time_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && (csr_addr_i == 12'hC01 || csr_addr_i == 12'hC81))
        |=> csr_illegal_o && $stable(delta));

    // R10: unowned addresses are ignored
    a_r10_unowned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_re_i || csr_we_i) && !known)
        |=> !csr_illegal_o && csr_rdata_o == '0);

endmodule

bind vtimedelta_csr vtd_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .time_i        (time_i),
    .priv_i        (priv_i),
    .virt_i        (virt_i),
    .csr_addr_i    (csr_addr_i),
    .csr_we_i      (csr_we_i),
    .csr_re_i      (csr_re_i),
    .csr_rdata_o   (csr_rdata_o),
    .csr_illegal_o (csr_illegal_o),
    .delta         (delta_w)
);

// File: tb/vtimedelta_csr_tb.sv
`timescale 1ns/1ps
module vtimedelta_csr_tb;

    typedef struct packed {
        logic        we;
        logic        re;
        logic [11:0] addr;
        logic [63:0] wdata;
        logic [1:0]  priv;
        logic        virt;
        logic [63:0] tm;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] T0 = 64'h0000_0001_FFFF_FFF0;
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 12'hC01, 64'h0, 2'd1, 1'b0, T0, 4'd2},
        '{1'b0, 1'b1, 12'hC01, 64'h0, 2'd1, 1'b1, T0, 4'd1},
        '{1'b1, 1'b0, 12'hA01, 64'h20, 2'd1, 1'b0, T0, 4'd4},
        '{1'b0, 1'b1, 12'hC01, 64'h0, 2'd0, 1'b1, T0, 4'd3},
        '{1'b0, 1'b1, 12'hC81, 64'h0, 2'd0, 1'b1, T0, 4'd6},
        '{1'b1, 1'b0, 12'hA81, 64'h5, 2'd3, 1'b0, T0, 4'd8},
        '{1'b0, 1'b1, 12'hA01, 64'h0, 2'd1, 1'b0, T0, 4'd5},
        '{1'b0, 1'b1, 12'hA81, 64'h0, 2'd1, 1'b0, T0, 4'd5},
        '{1'b1, 1'b0, 12'hA01, 64'hDEAD, 2'd1, 1'b1, T0, 4'd7},
        '{1'b1, 1'b0, 12'hA01, 64'hBEEF, 2'd0, 1'b0, T0, 4'd7},
        '{1'b0, 1'b1, 12'hA01, 64'h0, 2'd3, 1'b0, T0, 4'd7},
        '{1'b1, 1'b0, 12'hC01, 64'h77, 2'd3, 1'b0, T0, 4'd9},
        '{1'b0, 1'b1, 12'h300, 64'h0, 2'd3, 1'b0, T0, 4'd10},
        '{1'b0, 1'b1, 12'hC01, 64'h0, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2},
        '{1'b1, 1'b1, 12'hA01, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, T0, 4'd11},
        '{1'b0, 1'b1, 12'hC01, 64'h0, 2'd1, 1'b1, 64'h2, 4'd3},
        '{1'b0, 1'b1, 12'hC81, 64'h0, 2'd1, 1'b1, 64'h2, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_i = '0;
    logic [1:0]  priv_i = '0;
    logic        virt_i = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [63:0] rdata64;
    logic        ill64;
    logic [31:0] rdata32;
    logic        ill32;

    int checks = 0;
    int failures = 0;
    logic [63:0] m64 = '0;
    logic [63:0] m32 = '0;

    always #2.5 clk = ~clk;

    vtimedelta_csr #(.XLEN(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .priv_i(priv_i), .virt_i(virt_i),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_we_i(we), .csr_re_i(re),
        .csr_rdata_o(rdata64), .csr_illegal_o(ill64));

    vtimedelta_csr #(.XLEN(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .priv_i(priv_i), .virt_i(virt_i),
        .csr_addr_i(addr), .csr_wdata_i(wdata[31:0]), .csr_we_i(we), .csr_re_i(re),
        .csr_rdata_o(rdata32), .csr_illegal_o(ill32));

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected behaviour per requirement, for one width.
    task automatic model(input bit is32, input vec_t v, input logic [63:0] d,
                         output logic ill, output logic [63:0] rd, output logic [63:0] nd);
        logic hs_ok;
        logic hit;
        logic [63:0] seen;
        hs_ok = !v.virt && (v.priv == 2'd1 || v.priv == 2'd3);
        seen  = v.virt ? v.tm + d : v.tm;
        hit   = 1'b1;
        nd    = d;
        rd    = '0;
        ill   = 1'b0;
        case (v.addr)
            12'hA01: begin ill = !hs_ok;          rd = is32 ? {32'h0, d[31:0]} : d; end
            12'hA81: begin ill = !is32 || !hs_ok; rd = {32'h0, d[63:32]}; end
            12'hC01: begin ill = v.we;            rd = is32 ? {32'h0, seen[31:0]} : seen; end
            12'hC81: begin ill = !is32 || v.we;   rd = {32'h0, seen[63:32]}; end
            default: hit = 1'b0;
        endcase
        if (!hit || ill || !v.re) rd = '0;
        if (hit && v.we && !ill) begin
            if (v.addr == 12'hA01) begin
                if (is32) nd[31:0] = v.wdata[31:0];
                else      nd = v.wdata;
            end else if (v.addr == 12'hA81) begin
                nd[63:32] = v.wdata[31:0];
            end
        end
    endtask

    task automatic idle_inputs();
        we = 1'b0; re = 1'b0; addr = 12'h000; wdata = '0;
    endtask

    initial begin
        #(5.0 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 reset rdata64", rdata64, 64'h0);
        check("R1 reset illegal32", {63'h0, ill32}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic e_ill64, e_ill32;
            logic [63:0] e_rd64, e_rd32, n64, n32;
            v = VECS[i];
            model(1'b0, v, m64, e_ill64, e_rd64, n64);
            model(1'b1, v, m32, e_ill32, e_rd32, n32);
            we = v.we; re = v.re; addr = v.addr; wdata = v.wdata;
            priv_i = v.priv; virt_i = v.virt; time_i = v.tm;
            @(posedge clk);
            @(negedge clk);
            check({rname(v.req), " x64 rdata"},   rdata64, e_rd64);
            check({rname(v.req), " x64 illegal"}, {63'h0, ill64}, {63'h0, e_ill64});
            check({rname(v.req), " x32 rdata"},   {32'h0, rdata32}, e_rd32);
            check({rname(v.req), " x32 illegal"}, {63'h0, ill32}, {63'h0, e_ill32});
            m64 = n64; m32 = n32;
            idle_inputs();
        end

        // R11: a cycle with no access returns nothing
        @(posedge clk);
        @(negedge clk);
        check("R11 idle rdata64", rdata64, 64'h0);
        check("R11 idle illegal64", {63'h0, ill64}, 64'h0);

        // R4: full-width write then read back on the 64-bit instance
        we = 1'b1; addr = 12'hA01; priv_i = 2'd1; virt_i = 1'b0; wdata = 64'h1234_5678_9ABC_DEF0;
        @(posedge clk); @(negedge clk);
        we = 1'b0; re = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R4 full readback", rdata64, 64'h1234_5678_9ABC_DEF0);
        check("R5 low half readback", {32'h0, rdata32}, 64'h9ABC_DEF0);
        idle_inputs();

        // R1: reset clears the offset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        re = 1'b1; addr = 12'hC01; virt_i = 1'b1; priv_i = 2'd0; time_i = 64'h0000_0042_0000_0007;
        @(posedge clk); @(negedge clk);
        check("R1 offset zero after reset x64", rdata64, 64'h0000_0042_0000_0007);
        check("R1 offset zero after reset x32", {32'h0, rdata32}, 64'h0000_0007);
        idle_inputs();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule